// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two single-precision binary floating-point words over several clock cycles. Each word has one sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction behind an implicit leading one, so a normal word means (-1)^s x 1.f x 2^(e-127). A request is issued with a one-cycle `start` pulse. Some cycles later the block returns the sum on `sum_word`, together with overflow and underflow flags, for exactly one cycle of `sum_valid`.

The datapath works through a fixed sequence. It resolves special operands first. It then compares the exponents and shifts the smaller operand's significand right until its exponent matches the larger one, keeping guard, round and sticky bits. It adds or subtracts the significands according to the operand signs, then normalizes by shifting right or left. It rounds to nearest with ties to even. If rounding carries the significand out of range, it normalizes again. A result exponent that leaves the representable range produces an infinity or a signed zero and raises a flag, instead of a normal word.

The left-shift normalizer comes in two variants chosen by a parameter. The default counts leading zeros and shifts in one step. The other shifts one bit per cycle.

Top module: `fpa_add_sp`

## Requirements
- R1: For two normal operands of the same sign, `sum_word` is the correctly rounded sum, e.g. 0x3F800000 + 0x3F800000 = 0x40000000 and 0xBF000000 + 0xBE800000 = 0xBF400000.
- R2: The smaller operand is aligned by a right shift equal to the exponent gap. Every bit shifted beyond the round position is ORed into a sticky bit, and a gap wider than the working width leaves only the sticky bit (0x3F800000 + 0x33800001 = 0x3F800001, 0x3F800000 + 0x21800000 = 0x3F800000).
- R3: Rounding is to nearest, with ties resolved to an even fraction LSB (0x3F800000 + 0x33800000 = 0x3F800000, 0x3F800001 + 0x33800000 = 0x3F800002).
- R4: Operands of opposite sign are subtracted and the result takes the sign of the larger magnitude. An exact zero result is +0 (0x00000000), except that -0 plus -0 gives 0x80000000.
- R5: After a subtraction the result is shifted left until its leading one reaches the implicit-bit position, and the exponent drops by the shift count (0x3F800001 + 0xBF800000 = 0x34000000).
- R6: When rounding carries the significand to 2.0, the block normalizes again and increments the exponent (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R7: A final exponent of 255 or more yields a signed infinity (exponent all ones, fraction zero) with `flag_ovf` = 1 and `flag_uf` = 0.
- R8: A final exponent of 0 or below yields a zero carrying the result sign, with `flag_uf` = 1 and `flag_ovf` = 0.
- R9: An input with exponent field 0 is treated as a zero of its sign, whatever its fraction bits.
- R10: A NaN input, or infinities of opposite signs, give the quiet NaN 0x7FC00000. Otherwise an infinite input gives that infinity with no flag raised.
- R11: After reset `sum_valid`, `sum_word` and both flags are 0. A `start` seen while idle produces exactly one single-cycle `sum_valid` pulse. A `start` seen while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; the operands are captured when the block is idle |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| sum_valid | output | 1 | One-cycle pulse marking a new result |
| sum_word | output | 32 | Rounded sum, held until the next result |
| flag_ovf | output | 1 | Exponent overflow for the current result |
| flag_uf | output | 1 | Exponent underflow for the current result |

## Verification
On every cycle, the assertions check:
- that the handshake is a single pulse and that a request is accepted from idle;
- that the two flags never appear together, and that a flagged result is an infinity or a zero;
- that the rounding stage only ever sees a normalized significand;
- that any return from rounding to normalization carries a significand overflow.

Only the bench's operand scenarios can show whether the numeric value is right. These cover ties to even, sticky-driven rounding, deep cancellation, re-normalization, the special-operand rules and the discarding of a request made while busy.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Sequencer states of the adder
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_ADD,
      ST_NORM,
      ST_ROUND
   } fpa_state_e;

   // Operand classes after decoding
   typedef enum logic [1:0] {
      CLS_ZERO,
      CLS_NORM,
      CLS_INF,
      CLS_NAN
   } fpa_class_e;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
   import fpa_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word,
   output logic                  sign,
   output logic [EXP_W-1:0]      expo,
   output logic [FRAC_W:0]       sig,
   output fpa_class_e            cls
);

   logic [FRAC_W-1:0] frac;

   assign sign = word[EXP_W+FRAC_W];
   assign expo = word[EXP_W+FRAC_W-1:FRAC_W];
   assign frac = word[FRAC_W-1:0];

   // Exponent field 0 is read as zero (subnormals flushed, R9)
   always_comb begin
      sig = {1'b1, frac};
      cls = CLS_NORM;
      if (expo == '0) begin
         sig = '0;
         cls = CLS_ZERO;
      end else if (&expo) begin
         sig = '0;
         cls = (frac == '0) ? CLS_INF : CLS_NAN;
      end
   end

endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int SIG_W   = 24,
   parameter int GRS     = 3,
   parameter int SHIFT_W = 8
) (
   input  logic [SIG_W-1:0]     sig_in,
   input  logic [SHIFT_W-1:0]   shift,
   output logic [SIG_W+GRS-1:0] aligned
);

   localparam int EXT_W = SIG_W + GRS;

   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] moved;
   logic [EXT_W-1:0] lost_mask;

   always_comb begin
      ext       = {sig_in, {GRS{1'b0}}};
      moved     = ext >> shift;
      lost_mask = ~({EXT_W{1'b1}} << shift);
      if (int'(shift) >= EXT_W) begin
         aligned = {{(EXT_W-1){1'b0}}, |sig_in};
      end else begin
         aligned = {moved[EXT_W-1:1], moved[0] | (|(ext & lost_mask))};
      end
   end

   // R2: a nonzero significand never vanishes completely
   always_comb begin
      if (sig_in != '0) begin
         align_keep_chk: assert (aligned != '0);
      end
   end

endmodule

// File: rtl/fpa_norm_amt.sv
module fpa_norm_amt #(
   parameter int VAL_W  = 27,
   parameter int AMT_W  = 5,
   parameter bit SERIAL = 1'b0
) (
   input  logic [VAL_W-1:0] val,
   output logic [AMT_W-1:0] amt
);

   generate
      if (SERIAL) begin : g_serial
         logic unused_val;
         assign unused_val = ^val;
         assign amt        = AMT_W'(1);
      end else begin : g_lzc
         logic found;
         always_comb begin
            amt   = '0;
            found = 1'b0;
            for (int i = VAL_W - 1; i >= 0; i--) begin
               if (!found) begin
                  if (val[i]) found = 1'b1;
                  else        amt   = amt + AMT_W'(1);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
   parameter int SIG_W = 24
) (
   input  logic [SIG_W+2:0] sig_grs,
   output logic [SIG_W:0]   rounded
);

   logic keep_lsb, g_bit, r_bit, s_bit, bump;

   assign keep_lsb = sig_grs[3];
   assign g_bit    = sig_grs[2];
   assign r_bit    = sig_grs[1];
   assign s_bit    = sig_grs[0];

   // nearest, ties to even (R3)
   assign bump    = g_bit & (r_bit | s_bit | keep_lsb);
   assign rounded = {1'b0, sig_grs[SIG_W+2:3]} + (SIG_W+1)'(bump);

endmodule

// File: rtl/fpa_add_sp.sv
module fpa_add_sp
   import fpa_pkg::*;
#(
   parameter int EXP_W       = 8,
   parameter int FRAC_W      = 23,
   parameter bit NORM_SERIAL = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [EXP_W+FRAC_W:0]      opnd_a,
   input  logic [EXP_W+FRAC_W:0]      opnd_b,
   output logic                       sum_valid,
   output logic [EXP_W+FRAC_W:0]      sum_word,
   output logic                       flag_ovf,
   output logic                       flag_uf
);

   localparam int WORD_W  = 1 + EXP_W + FRAC_W;
   localparam int SIG_W   = FRAC_W + 1;
   localparam int GRS     = 3;
   localparam int EXT_W   = SIG_W + GRS;
   localparam int ACC_W   = EXT_W + 1;
   localparam int SE_W    = EXP_W + 2;
   localparam int AMT_W   = $clog2(ACC_W);
   localparam int EXP_MAX = (1 << EXP_W) - 1;
   localparam logic [WORD_W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   generate
      if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
         $error("fpa_add_sp: EXP_W out of range");
      end
      if (FRAC_W < 4) begin : g_bad_frac
         $error("fpa_add_sp: FRAC_W too small");
      end
   endgenerate

   fpa_state_e          state;
   logic [WORD_W-1:0]   a_q, b_q;
   logic                sign_q, eff_sub_q;
   logic [SE_W-1:0]     exp_q;
   logic [ACC_W-1:0]    acc_q;
   logic [EXT_W-1:0]    big_q, small_q;
   logic [WORD_W-1:0]   res_q;
   logic                ovf_q, uf_q, valid_q;

   // ---------------- operand decode and alignment ----------------
   logic               sa, sb;
   logic [EXP_W-1:0]   ea, eb;
   logic [SIG_W-1:0]   ma, mb;
   fpa_class_e         ca, cb;

   fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
      .word(a_q), .sign(sa), .expo(ea), .sig(ma), .cls(ca));
   fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
      .word(b_q), .sign(sb), .expo(eb), .sig(mb), .cls(cb));

   logic               a_big;
   logic [EXP_W-1:0]   exp_big, exp_small, exp_gap;
   logic [SIG_W-1:0]   sig_big, sig_small;
   logic [EXT_W-1:0]   small_al;

   assign a_big     = a_q[WORD_W-2:0] >= b_q[WORD_W-2:0];
   assign exp_big   = a_big ? ea : eb;
   assign exp_small = a_big ? eb : ea;
   assign sig_big   = a_big ? ma : mb;
   assign sig_small = a_big ? mb : ma;
   assign exp_gap   = exp_big - exp_small;

   fpa_align #(.SIG_W(SIG_W), .GRS(GRS), .SHIFT_W(EXP_W)) u_align (
      .sig_in(sig_small), .shift(exp_gap), .aligned(small_al));

   // special operands (R4 zeros, R9, R10)
   logic              spec_hit;
   logic [WORD_W-1:0] spec_word;

   always_comb begin
      spec_hit  = 1'b1;
      spec_word = '0;
      if (ca == CLS_NAN || cb == CLS_NAN ||
          (ca == CLS_INF && cb == CLS_INF && sa != sb)) begin
         spec_word = QNAN;
      end else if (ca == CLS_INF) begin
         spec_word = {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (cb == CLS_INF) begin
         spec_word = {sb, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (ca == CLS_ZERO && cb == CLS_ZERO) begin
         spec_word = {sa & sb, {(WORD_W-1){1'b0}}};
      end else if (ca == CLS_ZERO) begin
         spec_word = b_q;
      end else if (cb == CLS_ZERO) begin
         spec_word = a_q;
      end else begin
         spec_hit = 1'b0;
      end
   end

   // ---------------- add, normalize, round ----------------
   logic [ACC_W-1:0] add_res;
   assign add_res = eff_sub_q ? ({1'b0, big_q} - {1'b0, small_q})
                              : ({1'b0, big_q} + {1'b0, small_q});

   logic [AMT_W-1:0] norm_amt;
   fpa_norm_amt #(.VAL_W(ACC_W-1), .AMT_W(AMT_W), .SERIAL(NORM_SERIAL)) u_namt (
      .val(acc_q[ACC_W-2:0]), .amt(norm_amt));

   logic [SIG_W:0] rnd;
   fpa_round #(.SIG_W(SIG_W)) u_round (
      .sig_grs(acc_q[EXT_W-1:0]), .rounded(rnd));

   logic exp_low, exp_high;
   assign exp_low  = exp_q[SE_W-1] || (exp_q == '0);
   assign exp_high = exp_q >= SE_W'(EXP_MAX);

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         a_q       <= '0;
         b_q       <= '0;
         sign_q    <= 1'b0;
         eff_sub_q <= 1'b0;
         exp_q     <= '0;
         acc_q     <= '0;
         big_q     <= '0;
         small_q   <= '0;
         res_q     <= '0;
         ovf_q     <= 1'b0;
         uf_q      <= 1'b0;
         valid_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  a_q   <= opnd_a;
                  b_q   <= opnd_b;
                  state <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               if (spec_hit) begin
                  res_q   <= spec_word;
                  ovf_q   <= 1'b0;
                  uf_q    <= 1'b0;
                  valid_q <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  sign_q    <= a_big ? sa : sb;
                  eff_sub_q <= sa ^ sb;
                  exp_q     <= SE_W'(exp_big);
                  big_q     <= {sig_big, {GRS{1'b0}}};
                  small_q   <= small_al;
                  state     <= ST_ADD;
               end
            end
            ST_ADD: begin
               if (add_res == '0) begin
                  res_q   <= '0;
                  ovf_q   <= 1'b0;
                  uf_q    <= 1'b0;
                  valid_q <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  acc_q <= add_res;
                  state <= ST_NORM;
               end
            end
            ST_NORM: begin
               if (acc_q[ACC_W-1]) begin
                  acc_q <= {1'b0, acc_q[ACC_W-1:2], acc_q[1] | acc_q[0]};
                  exp_q <= exp_q + SE_W'(1);
               end else if (!acc_q[ACC_W-2]) begin
                  acc_q <= acc_q << norm_amt;
                  exp_q <= exp_q - SE_W'(norm_amt);
               end else begin
                  state <= ST_ROUND;
               end
            end
            ST_ROUND: begin
               if (exp_low) begin
                  res_q   <= {sign_q, {(WORD_W-1){1'b0}}};
                  ovf_q   <= 1'b0;
                  uf_q    <= 1'b1;
                  valid_q <= 1'b1;
                  state   <= ST_IDLE;
               end else if (rnd[SIG_W]) begin
                  acc_q <= {rnd, {GRS{1'b0}}};
                  state <= ST_NORM;
               end else if (exp_high) begin
                  res_q   <= {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                  ovf_q   <= 1'b1;
                  uf_q    <= 1'b0;
                  valid_q <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  res_q   <= {sign_q, exp_q[EXP_W-1:0], rnd[FRAC_W-1:0]};
                  ovf_q   <= 1'b0;
                  uf_q    <= 1'b0;
                  valid_q <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sum_valid = valid_q;
   assign sum_word  = res_q;
   assign flag_ovf  = ovf_q;
   assign flag_uf   = uf_q;

   // ---------------- assertions ----------------
   // R11
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state == ST_ALIGN));

   // R11
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_valid |=> !sum_valid);

   // R7
   ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_valid && flag_ovf) |->
         (sum_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && !flag_uf);

   // R8
   uf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_valid && flag_uf) |-> (sum_word[WORD_W-2:0] == '0) && !flag_ovf);

   // R5
   norm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ROUND) |-> (acc_q[ACC_W-2] && !acc_q[ACC_W-1]));

   // R6
   renorm_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NORM && $past(state) == ST_ROUND) |-> acc_q[ACC_W-1]);

endmodule

// File: tb/fpa_add_sp_tb.sv
`timescale 1ns/1ps
module fpa_add_sp_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        sum_valid;
   logic [31:0] sum_word;
   logic        flag_ovf, flag_uf;

   always #2.5 clk = ~clk;

   fpa_add_sp u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .sum_valid(sum_valid), .sum_word(sum_word),
      .flag_ovf(flag_ovf), .flag_uf(flag_uf));

   typedef struct {
      logic [31:0] word;
      logic        ovf;
      logic        uf;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t mon_e;
   int   n_tests = 0;
   int   n_fail  = 0;
   int   n_pulse = 0;
   int   n_sent  = 0;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, expv);
      end
   endtask

   // driver: pushes the expected item, then pulses start
   task automatic send(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] res, input logic ovf,
                       input logic uf, input string tag);
      exp_t e;
      e.word = res; e.ovf = ovf; e.uf = uf; e.tag = tag;
      sb_q.push_back(e);
      n_sent++;
      @(negedge clk);
      opnd_a = a; opnd_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 300 && sb_q.size() != 0; i++) @(negedge clk);
      if (sb_q.size() != 0) begin
         check(1'b0, {tag, " no result"}, '0, res);
         sb_q.delete();
      end
   endtask

   // monitor: compares each result with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && sum_valid) begin
         n_pulse++;
         if (sb_q.size() == 0) begin
            check(1'b0, "R11 unexpected result", sum_word, '0);
         end else begin
            mon_e = sb_q.pop_front();
            check(sum_word == mon_e.word, {mon_e.tag, " word"}, sum_word, mon_e.word);
            check({flag_ovf, flag_uf} == {mon_e.ovf, mon_e.uf}, {mon_e.tag, " flags"},
                  {30'd0, flag_ovf, flag_uf}, {30'd0, mon_e.ovf, mon_e.uf});
         end
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      check({sum_valid, flag_ovf, flag_uf} == 3'b000, "R11 reset flags",
            {29'd0, sum_valid, flag_ovf, flag_uf}, 32'd0);
      check(sum_word == 32'd0, "R11 reset word", sum_word, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0, "R1 1+1");
      send(32'h3FC00000, 32'h3E800000, 32'h3FE00000, 0, 0, "R1 1.5+0.25");
      send(32'hBF000000, 32'hBE800000, 32'hBF400000, 0, 0, "R1 neg sum");
      send(32'h3F800000, 32'h33800001, 32'h3F800001, 0, 0, "R2 sticky up");
      send(32'h3F800000, 32'h21800000, 32'h3F800000, 0, 0, "R2 far gap");
      send(32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0, "R3 tie even down");
      send(32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0, "R3 tie odd up");
      send(32'h3F800000, 32'hBF400000, 32'h3E800000, 0, 0, "R4 1-0.75");
      send(32'hC0000000, 32'h3F800000, 32'hBF800000, 0, 0, "R4 sign of larger");
      send(32'h40400000, 32'hC0400000, 32'h00000000, 0, 0, "R4 exact zero");
      send(32'h80000000, 32'h80000000, 32'h80000000, 0, 0, "R4 neg zeros");
      send(32'h3F800001, 32'hBF800000, 32'h34000000, 0, 0, "R5 cancel");
      send(32'h3FFFFFFF, 32'h33800000, 32'h40000000, 0, 0, "R6 renorm");
      send(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0, "R7 overflow");
      send(32'hFF7FFFFF, 32'hFF000000, 32'hFF800000, 1, 0, "R7 neg overflow");
      send(32'h00800001, 32'h80800000, 32'h00000000, 0, 1, "R8 underflow");
      send(32'h00400000, 32'h3F800000, 32'h3F800000, 0, 0, "R9 subnormal");
      send(32'h00400000, 32'h80200000, 32'h00000000, 0, 0, "R9 two subnormals");
      send(32'h7FC12345, 32'h3F800000, 32'h7FC00000, 0, 0, "R10 nan in");
      send(32'h7F800000, 32'hFF800000, 32'h7FC00000, 0, 0, "R10 inf-inf");
      send(32'h3F800000, 32'hFF800000, 32'hFF800000, 0, 0, "R10 inf pass");

      // R11: start held while busy with other operands must be ignored
      begin
         exp_t e;
         e.word = 32'h40000000; e.ovf = 1'b0; e.uf = 1'b0; e.tag = "R11 busy start";
         sb_q.push_back(e);
         n_sent++;
         @(negedge clk);
         opnd_a = 32'h3F800000; opnd_b = 32'h3F800000; start = 1'b1;
         @(negedge clk);
         opnd_a = 32'h40400000; opnd_b = 32'h40400000;
         @(negedge clk);
         start = 1'b0;
         for (int i = 0; i < 300 && sb_q.size() != 0; i++) @(negedge clk);
         repeat (30) @(negedge clk);
      end
      check(n_pulse == n_sent, "R11 pulse count", n_pulse, n_sent);
      check(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 32'd0);

      finish_run();
   end

endmodule